// File: doc/BRIEF.md
# Clock Synchronous Serial Port

This block is a full-duplex serial port in which transmit and receive share one shift clock. A small register bus reaches four registers: the data location (a write fills the transmit holding buffer, a read takes the receive holding buffer), a status location, a control location and a rate location. A byte written to the data location moves into the transmit shift register as soon as the engine is free. It then leaves on `txd` least significant bit first. At the same time the bits on `rxd` are gathered into a receive shift register.

The shift clock comes from one of two sources. The first is an internal divider: an optional fixed prescaler, then a reload counter that divides by n+1, then a toggle stage. The second is the external `sclk_in` pin, which is synchronised to the system clock. Data is launched on falling edges and captured on rising edges. If a byte is written while a shift is still running, it follows the current byte with no pause in the clock. Status flags report an empty transmit buffer, a finished shift, a full receive buffer and overrun. Two one-cycle interrupt pulses report transmit and receive events.

Top module: `sync_serial_port`

## Requirements
- R1: While control bit 6 (engine enable) is 0, `sclk_out` and `txd` stay high, a byte written to the data location (address 0) is not shifted, and the shift-complete flag (status bit 2) stays 1.
- R2: When the internal clock is used, each half period of `sclk_out` lasts P*(n+1) system cycles. P is 4 when control bit 1 is set and 1 otherwise; n is the rate register (address 3). A full shift period therefore spans 2 to 2048 cycles.
- R3: A write to the data location clears the buffer-empty flag (status bit 0). If the engine is idle, the byte moves to the shift register on the next cycle, which sets buffer-empty to 1 and clears shift-complete to 0.
- R4: `txd` presents the byte least significant bit first and changes only when the shift clock falls; `sclk_out` idles high.
- R5: `rxd` is sampled on rising edges, least significant bit first. When the last bit arrives and the receiver is enabled, the byte enters the receive buffer (read at address 0). In that same cycle receive-full (status bit 1) is set and `rx_irq` pulses for one cycle.
- R6: Shift-complete returns to 1 only after the final rising edge of a byte when no further byte waits; `sclk_out` is high at that point.
- R7: `tx_irq` pulses for one cycle. It fires when buffer-empty rises if control bit 2 is 0, and when shift-complete rises if control bit 2 is 1.
- R8: A byte written while shift-complete is 0 follows the current byte directly, with the shift-clock period unchanged across the boundary.
- R9: A byte that completes while receive-full is 1 sets the overrun flag (status bit 3). The buffer keeps the earlier byte and no `rx_irq` fires. Writing the status location (address 1) clears the overrun flag.
- R10: Reading the data location clears receive-full.
- R11: `rx_ready` is high exactly when control bits 6 and 3 (receiver enable) are both set. While bit 3 is 0, received bytes are discarded.
- R12: When control bit 0 is set, the shift clock is taken from `sclk_in` after synchronisation and `sclk_oe` is low. In internal mode with the engine enabled, `sclk_oe` is high.
- R13: After reset the status location reads 0x05, `sclk_out` and `txd` are high, and both interrupt outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register select: 0 data, 1 status, 2 control, 3 rate |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clears receive-full on the data location) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| sclk_in | input | 1 | External shift clock |
| sclk_out | output | 1 | Internal shift clock, idle high |
| sclk_oe | output | 1 | Drive enable for the shift clock pin |
| rxd | input | 1 | Serial receive data |
| txd | output | 1 | Serial transmit data |
| rx_ready | output | 1 | Receiver enabled and ready |
| tx_irq | output | 1 | Transmit interrupt pulse |
| rx_irq | output | 1 | Receive interrupt pulse |

## Verification
The properties assume that control bits are not rewritten while a byte is being shifted. They also assume that `sclk_in`, when selected, holds each level for well over the synchroniser depth plus one cycle, so no edge is lost or merged. The stimulus meets both conditions. It writes control only right after a reset, before any byte is loaded, and it holds each external clock level for twelve system cycles, with `rxd` changed only in the low phase.

// File: rtl/ssp_pkg.sv
`timescale 1ns/1ps
package ssp_pkg;
   localparam int unsigned BUS_W = 8;

   typedef enum logic [1:0] {
      SEL_DATA = 2'd0,
      SEL_STAT = 2'd1,
      SEL_CTRL = 2'd2,
      SEL_RATE = 2'd3
   } reg_sel_e;

   // control field positions
   localparam int unsigned C_EXT  = 0;
   localparam int unsigned C_PRE  = 1;
   localparam int unsigned C_TXI  = 2;
   localparam int unsigned C_RXEN = 3;
   localparam int unsigned C_RUN  = 6;

   // status field positions
   localparam int unsigned S_TBE = 0;
   localparam int unsigned S_RBF = 1;
   localparam int unsigned S_TSC = 2;
   localparam int unsigned S_OVR = 3;

   typedef struct packed {
      logic run;
      logic rx_en;
      logic txi_on_done;
      logic pre_div;
      logic ext_clk;
   } ctrl_t;
endpackage

// File: rtl/ssp_baud_gen.sv
`timescale 1ns/1ps
module ssp_baud_gen #(
   parameter int unsigned BAUD_W  = 8,
   parameter int unsigned PRE_DIV = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              use_pre,
   input  logic [BAUD_W-1:0] reload,
   output logic              tick
);
   logic              pre_stb;
   logic [BAUD_W-1:0] cnt_q;

   generate
      if (PRE_DIV > 1) begin : g_pre
         localparam int unsigned PC_W = $clog2(PRE_DIV);
         logic [PC_W-1:0] pc_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                           pc_q <= '0;
            else if (!run)                        pc_q <= '0;
            else if (pc_q == PC_W'(PRE_DIV - 1))  pc_q <= '0;
            else                                  pc_q <= pc_q + 1'b1;
         end
         assign pre_stb = !use_pre || (pc_q == PC_W'(PRE_DIV - 1));
      end else begin : g_nopre
         logic unused_pre;
         assign unused_pre = use_pre;
         assign pre_stb    = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt_q <= '0;
      else if (!run)      cnt_q <= reload;
      else if (pre_stb)   cnt_q <= (cnt_q == '0) ? reload : cnt_q - 1'b1;
   end

   assign tick = run && pre_stb && (cnt_q == '0);
endmodule

// File: rtl/ssp_edge_sync.sv
`timescale 1ns/1ps
module ssp_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic rise,
   output logic fall
);
   logic [STAGES-1:0] sync_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '1;
         prev_q <= 1'b1;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], pin};
         prev_q <= sync_q[STAGES-1];
      end
   end

   assign rise = sync_q[STAGES-1] && !prev_q;
   assign fall = !sync_q[STAGES-1] && prev_q;
endmodule

// File: rtl/ssp_shift_engine.sv
`timescale 1ns/1ps
module ssp_shift_engine #(
   parameter int unsigned FRAME_BITS = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  enable,
   input  logic                  use_ext,
   input  logic                  tick,
   input  logic                  ext_rise,
   input  logic                  ext_fall,
   input  logic                  pending,
   input  logic [FRAME_BITS-1:0] tx_word,
   input  logic                  rxd,
   output logic                  sclk_o,
   output logic                  txd_o,
   output logic                  busy_o,
   output logic                  take_o,
   output logic                  done_o,
   output logic                  finish_o,
   output logic [FRAME_BITS-1:0] rx_word_o
);
   localparam int unsigned CNT_W = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;

   logic                  busy_q, sclk_q, txd_q;
   logic [FRAME_BITS-1:0] tx_sr_q;
   logic [FRAME_BITS-1:1] rx_sr_q;
   logic [CNT_W-1:0]      bit_q;
   logic                  fall_w, rise_w, last_w;

   assign fall_w    = busy_q && (use_ext ? ext_fall : (tick && sclk_q));
   assign rise_w    = busy_q && (use_ext ? ext_rise : (tick && !sclk_q));
   assign last_w    = (bit_q == CNT_W'(FRAME_BITS - 1));
   assign done_o    = rise_w && last_w;
   assign take_o    = enable && pending && (!busy_q || done_o);
   assign finish_o  = done_o && !pending;
   assign rx_word_o = {rxd, rx_sr_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         sclk_q  <= 1'b1;
         txd_q   <= 1'b1;
         tx_sr_q <= '0;
         rx_sr_q <= '0;
         bit_q   <= '0;
      end else if (!enable) begin
         busy_q <= 1'b0;
         sclk_q <= 1'b1;
         txd_q  <= 1'b1;
         bit_q  <= '0;
      end else begin
         if (fall_w) begin
            sclk_q  <= 1'b0;
            txd_q   <= tx_sr_q[0];
            tx_sr_q <= tx_sr_q >> 1;
         end
         if (rise_w) begin
            sclk_q  <= 1'b1;
            rx_sr_q <= rx_word_o[FRAME_BITS-1:1];
            bit_q   <= last_w ? '0 : bit_q + 1'b1;
         end
         if (take_o) begin
            tx_sr_q <= tx_word;
            busy_q  <= 1'b1;
         end else if (finish_o) begin
            busy_q  <= 1'b0;
         end
      end
   end

   assign sclk_o = sclk_q;
   assign txd_o  = txd_q;
   assign busy_o = busy_q;
endmodule

// File: rtl/sync_serial_port.sv
`timescale 1ns/1ps
module sync_serial_port
   import ssp_pkg::*;
#(
   parameter int unsigned FRAME_BITS  = 8,
   parameter int unsigned BAUD_W      = 8,
   parameter int unsigned PRE_DIV     = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       bus_addr,
   input  logic             bus_wr,
   input  logic             bus_rd,
   input  logic [BUS_W-1:0] bus_wdata,
   output logic [BUS_W-1:0] bus_rdata,
   input  logic             sclk_in,
   output logic             sclk_out,
   output logic             sclk_oe,
   input  logic             rxd,
   output logic             txd,
   output logic             rx_ready,
   output logic             tx_irq,
   output logic             rx_irq
);
   generate
      if (FRAME_BITS < 2 || FRAME_BITS > BUS_W) begin : g_bad_frame
         $error("FRAME_BITS must lie in 2..BUS_W");
      end
      if (BAUD_W < 1 || BAUD_W > BUS_W) begin : g_bad_baud
         $error("BAUD_W must lie in 1..BUS_W");
      end
      if (PRE_DIV < 1) begin : g_bad_pre
         $error("PRE_DIV must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   ctrl_t                 ctrl_q;
   logic [BAUD_W-1:0]     rate_q;
   logic [FRAME_BITS-1:0] tx_buf_q, rx_buf_q;
   logic                  tbe_q, tsc_q, rbf_q, ovr_q;
   logic                  tx_irq_q, rx_irq_q;

   logic wr_data, wr_stat, wr_ctrl, wr_rate, rd_data;
   logic tick, ext_rise, ext_fall;
   logic eng_sclk, eng_txd, busy, take, done, finish;
   logic [FRAME_BITS-1:0] rx_word;
   logic store_ok, overrun;

   // named copies for the bound checker
   logic sync_en;
   assign sync_en = ctrl_q.run;

   assign wr_data = bus_wr && (reg_sel_e'(bus_addr) == SEL_DATA);
   assign wr_stat = bus_wr && (reg_sel_e'(bus_addr) == SEL_STAT);
   assign wr_ctrl = bus_wr && (reg_sel_e'(bus_addr) == SEL_CTRL);
   assign wr_rate = bus_wr && (reg_sel_e'(bus_addr) == SEL_RATE);
   assign rd_data = bus_rd && (reg_sel_e'(bus_addr) == SEL_DATA);

   ssp_baud_gen #(.BAUD_W(BAUD_W), .PRE_DIV(PRE_DIV)) u_rate (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (ctrl_q.run && busy && !ctrl_q.ext_clk),
      .use_pre (ctrl_q.pre_div),
      .reload  (rate_q),
      .tick    (tick)
   );

   ssp_edge_sync #(.STAGES(SYNC_STAGES)) u_ext (
      .clk   (clk),
      .rst_n (rst_n),
      .pin   (sclk_in),
      .rise  (ext_rise),
      .fall  (ext_fall)
   );

   ssp_shift_engine #(.FRAME_BITS(FRAME_BITS)) u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (ctrl_q.run),
      .use_ext   (ctrl_q.ext_clk),
      .tick      (tick),
      .ext_rise  (ext_rise),
      .ext_fall  (ext_fall),
      .pending   (!tbe_q),
      .tx_word   (tx_buf_q),
      .rxd       (rxd),
      .sclk_o    (eng_sclk),
      .txd_o     (eng_txd),
      .busy_o    (busy),
      .take_o    (take),
      .done_o    (done),
      .finish_o  (finish),
      .rx_word_o (rx_word)
   );

   assign store_ok = done && ctrl_q.rx_en && (!rbf_q || rd_data);
   assign overrun  = done && ctrl_q.rx_en && rbf_q && !rd_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         rate_q   <= '0;
         tx_buf_q <= '0;
         rx_buf_q <= '0;
         tbe_q    <= 1'b1;
         tsc_q    <= 1'b1;
         rbf_q    <= 1'b0;
         ovr_q    <= 1'b0;
         tx_irq_q <= 1'b0;
         rx_irq_q <= 1'b0;
      end else begin
         if (wr_ctrl) begin
            ctrl_q.run         <= bus_wdata[C_RUN];
            ctrl_q.rx_en       <= bus_wdata[C_RXEN];
            ctrl_q.txi_on_done <= bus_wdata[C_TXI];
            ctrl_q.pre_div     <= bus_wdata[C_PRE];
            ctrl_q.ext_clk     <= bus_wdata[C_EXT];
         end
         if (wr_rate) rate_q <= bus_wdata[BAUD_W-1:0];
         if (wr_data) tx_buf_q <= bus_wdata[FRAME_BITS-1:0];

         if (wr_data)   tbe_q <= 1'b0;
         else if (take) tbe_q <= 1'b1;

         if (!ctrl_q.run)         tsc_q <= 1'b1;
         else if (take && !busy)  tsc_q <= 1'b0;
         else if (finish)         tsc_q <= 1'b1;

         if (store_ok) begin
            rbf_q    <= 1'b1;
            rx_buf_q <= rx_word;
         end else if (rd_data) begin
            rbf_q    <= 1'b0;
         end

         if (overrun)      ovr_q <= 1'b1;
         else if (wr_stat) ovr_q <= 1'b0;

         tx_irq_q <= ctrl_q.txi_on_done ? (finish && ctrl_q.run) : (take && !wr_data);
         rx_irq_q <= store_ok;
      end
   end

   always_comb begin
      bus_rdata = '0;
      unique case (reg_sel_e'(bus_addr))
         SEL_DATA: bus_rdata[FRAME_BITS-1:0] = rx_buf_q;
         SEL_STAT: begin
            bus_rdata[S_TBE] = tbe_q;
            bus_rdata[S_RBF] = rbf_q;
            bus_rdata[S_TSC] = tsc_q;
            bus_rdata[S_OVR] = ovr_q;
         end
         SEL_CTRL: begin
            bus_rdata[C_RUN]  = ctrl_q.run;
            bus_rdata[C_RXEN] = ctrl_q.rx_en;
            bus_rdata[C_TXI]  = ctrl_q.txi_on_done;
            bus_rdata[C_PRE]  = ctrl_q.pre_div;
            bus_rdata[C_EXT]  = ctrl_q.ext_clk;
         end
         SEL_RATE: bus_rdata[BAUD_W-1:0] = rate_q;
         default:  bus_rdata = '0;
      endcase
   end

   assign sclk_out = ctrl_q.ext_clk ? 1'b1 : eng_sclk;
   assign sclk_oe  = ctrl_q.run && !ctrl_q.ext_clk;
   assign txd      = eng_txd;
   assign rx_ready = ctrl_q.run && ctrl_q.rx_en;
   assign tx_irq   = tx_irq_q;
   assign rx_irq   = rx_irq_q;
endmodule

// File: rtl/ssp_checker.sv
`timescale 1ns/1ps
module ssp_checker (
   input logic clk,
   input logic rst_n,
   input logic sync_en,
   input logic sclk_out,
   input logic txd,
   input logic tx_irq,
   input logic rx_irq,
   input logic tbe,
   input logic tsc,
   input logic rbf,
   input logic oe
);
   p_quiet_when_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!sync_en && $past(!sync_en)) |-> (sclk_out && txd));

   p_txd_steady_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(sclk_out) && sync_en) |-> $stable(txd));

   p_rx_irq_with_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rx_irq |-> rbf);

   p_clock_high_when_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
      tsc |-> sclk_out);

   p_tx_irq_on_flag_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tx_irq |-> ($rose(tsc) || $rose(tbe)));

   p_overrun_needs_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(oe) |-> $past(rbf));
endmodule

bind sync_serial_port ssp_checker u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .sync_en  (sync_en),
   .sclk_out (sclk_out),
   .txd      (txd),
   .tx_irq   (tx_irq),
   .rx_irq   (rx_irq),
   .tbe      (tbe_q),
   .tsc      (tsc_q),
   .rbf      (rbf_q),
   .oe       (ovr_q)
);

// File: tb/sync_serial_port_tb.sv
`timescale 1ns/1ps
module sync_serial_port_tb;
   localparam int CLK_NS = 8;
   localparam logic [7:0] C_RUN_V = 8'h40, C_RXEN_V = 8'h08, C_TXI_V = 8'h04,
                          C_PRE_V = 8'h02, C_EXT_V = 8'h01;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] bus_addr = 2'd1;
   logic       bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0] bus_wdata = '0, bus_rdata;
   logic       sclk_in = 1'b1, sclk_out, sclk_oe;
   logic       rxd, txd, rx_ready, tx_irq, rx_irq;
   logic       loop_en = 1'b0, rxd_drv = 1'b1;

   int checks = 0, failures = 0;
   int tx_irq_cnt = 0, rx_irq_cnt = 0, fall_cnt = 0;
   bit finished = 1'b0;

   assign rxd = loop_en ? txd : rxd_drv;

   always #(CLK_NS/2) clk = ~clk;

   sync_serial_port u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk_in(sclk_in), .sclk_out(sclk_out),
      .sclk_oe(sclk_oe), .rxd(rxd), .txd(txd), .rx_ready(rx_ready), .tx_irq(tx_irq),
      .rx_irq(rx_irq));

   always @(posedge clk) begin
      if (rst_n) begin
         if (tx_irq) tx_irq_cnt++;
         if (rx_irq) rx_irq_cnt++;
      end
   end
   always @(negedge sclk_out) fall_cnt++;

   task automatic chk(input string tag, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; loop_en = 1'b0;
      rxd_drv = 1'b1; sclk_in = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      tx_irq_cnt = 0; rx_irq_cnt = 0;
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic peek(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic wait_done();
      logic [7:0] s;
      bit hit = 1'b0;
      for (int i = 0; i < 40000 && !hit; i++) begin
         peek(2'd1, s);
         if (s[2]) hit = 1'b1;
      end
   endtask

   task automatic collect(input int nb, output logic [15:0] bits,
                          output longint pmin, output longint pmax);
      longint t_prev, t_now;
      bits = '0; pmin = 64'd1 << 40; pmax = 0; t_prev = 0;
      for (int i = 0; i < nb; i++) begin
         @(negedge sclk_out);
         t_now = $time;
         if (i > 0) begin
            if (t_now - t_prev < pmin) pmin = t_now - t_prev;
            if (t_now - t_prev > pmax) pmax = t_now - t_prev;
         end
         t_prev = t_now;
         @(posedge sclk_out);
         #1 bits[i] = txd;
      end
   endtask

   task automatic t_reset_state();
      logic [7:0] s;
      do_reset();
      peek(2'd1, s);
      chk("R13 reset status", s, 8'h05);
      chk("R13 reset sclk_out", sclk_out, 1);
      chk("R13 reset txd", txd, 1);
      chk("R13 reset irqs", {tx_irq, rx_irq}, 0);
      chk("R11 ready low after reset", rx_ready, 0);
   endtask

   task automatic t_disabled();
      logic [7:0] s;
      int f0;
      do_reset();
      bus_write(2'd2, C_RXEN_V);
      f0 = fall_cnt;
      bus_write(2'd0, 8'hA5);
      repeat (40) @(negedge clk);
      peek(2'd1, s);
      chk("R1 no clock when off", fall_cnt - f0, 0);
      chk("R1 status when off", s, 8'h04);
      chk("R1 txd high when off", txd, 1);
      chk("R11 ready needs run bit", rx_ready, 0);
   endtask

   task automatic t_internal(input logic [7:0] n, input bit pre, input bit txi_done,
                             input logic [7:0] b);
      logic [7:0] s, d;
      logic [15:0] bits;
      longint pmin, pmax, exp_per;
      do_reset();
      bus_write(2'd3, n);
      bus_write(2'd2, C_RUN_V | C_RXEN_V | (pre ? C_PRE_V : 8'h00) | (txi_done ? C_TXI_V : 8'h00));
      chk("R11 ready when enabled", rx_ready, 1);
      chk("R12 clock driven in internal mode", sclk_oe, 1);
      loop_en = 1'b1;
      bus_write(2'd0, b);
      bus_addr = 2'd1;
      #2 s = bus_rdata;
      chk("R3 status right after write", s, 8'h04);
      @(negedge clk);
      #1 s = bus_rdata;
      chk("R3 status after load", s, 8'h01);
      exp_per = 2 * (pre ? 4 : 1) * (longint'(n) + 1) * CLK_NS;
      collect(8, bits, pmin, pmax);
      chk("R7 tx irq before end", tx_irq_cnt, txi_done ? 0 : 1);
      chk("R4 bits lsb first", bits[7:0], b);
      chk("R2 period min", pmin, exp_per);
      chk("R2 period max", pmax, exp_per);
      wait_done();
      peek(2'd1, s);
      chk("R6 R5 status at end", s, 8'h07);
      chk("R6 clock idle high", sclk_out, 1);
      chk("R5 rx irq count", rx_irq_cnt, 1);
      chk("R7 tx irq count", tx_irq_cnt, 1);
      bus_read(2'd0, d);
      chk("R5 received byte", d, b);
      peek(2'd1, s);
      chk("R10 read clears full", s, 8'h05);
   endtask

   task automatic t_back_to_back();
      logic [7:0] s, d;
      logic [15:0] bits;
      longint pmin, pmax;
      bit hit = 1'b0;
      do_reset();
      bus_write(2'd3, 8'd3);
      bus_write(2'd2, C_RUN_V | C_RXEN_V);
      loop_en = 1'b1;
      bus_write(2'd0, 8'h3C);
      for (int i = 0; i < 20 && !hit; i++) begin
         peek(2'd1, s);
         if (s[0]) hit = 1'b1;
      end
      bus_write(2'd0, 8'hE1);
      collect(16, bits, pmin, pmax);
      chk("R8 bits of both bytes", bits, 16'hE13C);
      chk("R8 no gap min", pmin, 64);
      chk("R8 no gap max", pmax, 64);
      wait_done();
      peek(2'd1, s);
      chk("R9 overrun status", s, 8'h0F);
      chk("R9 no irq for lost byte", rx_irq_cnt, 1);
      chk("R7 two buffer-empty irqs", tx_irq_cnt, 2);
      bus_read(2'd0, d);
      chk("R9 buffer keeps first byte", d, 8'h3C);
      bus_write(2'd1, 8'h00);
      peek(2'd1, s);
      chk("R9 status write clears overrun", s, 8'h05);
   endtask

   task automatic t_rx_disabled();
      logic [7:0] s;
      do_reset();
      bus_write(2'd3, 8'd1);
      bus_write(2'd2, C_RUN_V);
      chk("R11 ready low without rx enable", rx_ready, 0);
      loop_en = 1'b1;
      bus_write(2'd0, 8'h77);
      repeat (3) @(negedge clk);
      wait_done();
      peek(2'd1, s);
      chk("R11 byte discarded", s, 8'h05);
      chk("R11 no rx irq", rx_irq_cnt, 0);
   endtask

   task automatic t_external();
      logic [7:0] s, d, tx_seen;
      localparam logic [7:0] RX_B = 8'h96;
      do_reset();
      bus_write(2'd2, C_RUN_V | C_RXEN_V | C_EXT_V);
      chk("R12 pin not driven", sclk_oe, 0);
      bus_write(2'd0, 8'hC3);
      repeat (3) @(negedge clk);
      tx_seen = '0;
      for (int i = 0; i < 8; i++) begin
         sclk_in = 1'b0;
         repeat (6) @(negedge clk);
         rxd_drv = RX_B[i];
         repeat (6) @(negedge clk);
         tx_seen[i] = txd;
         sclk_in = 1'b1;
         repeat (12) @(negedge clk);
      end
      peek(2'd1, s);
      chk("R12 status after external byte", s, 8'h07);
      chk("R12 sclk_out stays high", sclk_out, 1);
      chk("R12 R4 transmitted bits", tx_seen, 8'hC3);
      bus_read(2'd0, d);
      chk("R12 R5 received bits", d, RX_B);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL R13 watchdog actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      t_reset_state();
      t_disabled();
      t_internal(8'd0, 1'b0, 1'b0, 8'hA5);
      t_internal(8'd5, 1'b1, 1'b0, 8'h4E);
      t_internal(8'd2, 1'b0, 1'b1, 8'h81);
      t_internal(8'd255, 1'b1, 1'b1, 8'h5B);
      t_back_to_back();
      t_rx_disabled();
      t_external();
      summary();
      $finish;
   end
endmodule